// File: doc/BRIEF.md
# Addressable Latch with Demultiplexer Mode

This block is a bank of eight single-bit storage cells. A binary select chooses one cell, and a lone data bit is written into it. Two active-low controls choose the operating mode. The clear input wipes the bank. The enable input opens a write. When clear and enable are both asserted, the block stops acting as storage and becomes a one-of-eight decoder: the data bit is routed to the selected output and every other output is held low.

The block runs in a single clock domain. While the enable is low, the select and data are sampled on each clock edge. The write lands on the edge at which the enable is first seen high again, and it uses the last values sampled. Clear takes effect without waiting for a clock. It empties the bank and drops any write that has been opened but not yet committed. Clear is released through a reset synchronizer, so the bank stays in reset for `SYNC_STAGES` edges after clear goes high.

Top module: `sel_latch_demux`

## Requirements
- R1: After `rst_n` is released, with `clr_n` and `wr_en_n` both high, `q` is all zeros.
- R2: With `clr_n` high, a low pulse on `wr_en_n` changes only the selected bit of `q`. The change is visible after the first clock edge that samples `wr_en_n` high. The other seven bits keep their values.
- R3: `sel` is an unsigned binary number, and value n selects bit n of `q` (0 selects `q[0]`, 7 selects `q[7]`).
- R4: While `clr_n` and `wr_en_n` are high and no write is pending, changes on `sel` and `din` leave `q` unchanged.
- R5: If `sel` or `din` changes during one low period of `wr_en_n`, only the values sampled at the last clock edge of that period are written. Earlier samples leave no trace.
- R6: While `clr_n` and `wr_en_n` are both low, `q` equals `din` on the bit selected by `sel` and 0 on all other bits. This output follows the inputs with no clock edge.
- R7: While `clr_n` is low and `wr_en_n` is high, `q` is all zeros, whatever `sel` and `din` are. This takes effect as soon as `clr_n` falls, with no clock edge.
- R8: A clear erases the stored contents. After `clr_n` returns high, `q` reads all zeros until a new write. A write that starts `SYNC_STAGES` or more edges after the release is accepted normally.
- R9: If clear is asserted after a write has opened but before it commits, the write is discarded. It does not appear once clear is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the enable, select and data |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 1 | Data bit to store or to route |
| sel | input | 3 | Binary index of the target bit |
| wr_en_n | input | 1 | Active-low write enable; a write commits when it returns high |
| clr_n | input | 1 | Active-low clear; together with a low enable it selects demultiplex mode |
| q | output | 8 | Parallel output |

## Verification
The hardest case to reach is a clear that arrives while a write is pending. It needs select and data captured during an enable-low period, with clear falling before the enable rises. The enable must then rise while clear is still low, so that the commit edge meets a bank held in reset. The bench first fills the bank with a known pattern. It then opens a write, drops clear, and spends a few edges in demultiplex mode. Next it raises the enable under clear and releases clear later. After that it checks that no trace of the write or the old pattern remains, and that a write issued after the synchronizer window is accepted.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } sld_mode_e;

  function automatic sld_mode_e mode_of(input logic clr_n, input logic en_n);
    if (clr_n) return en_n ? MODE_HOLD : MODE_WRITE;
    else       return en_n ? MODE_CLEAR : MODE_DEMUX;
  endfunction
endpackage

// File: rtl/sld_rst_sync.sv
module sld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sld_capture.sv
module sld_capture #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             en_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             commit,
  output logic [SEL_W-1:0] cmt_sel,
  output logic             cmt_din
);
  logic             pend_q, pend_d;
  logic [SEL_W-1:0] sel_q;
  logic             din_q;
  logic             load;

  always_comb begin
    load   = !en_n;
    pend_d = load;
    commit = pend_q && en_n;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
      din_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (load) begin
        sel_q <= sel;
        din_q <= din;
      end
    end
  end

  assign cmt_sel = sel_q;
  assign cmt_din = din_q;
endmodule

// File: rtl/sld_store.sv
module sld_store #(
  parameter int WIDTH = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             commit,
  input  logic [SEL_W-1:0] cmt_sel,
  input  logic             cmt_din,
  output logic [WIDTH-1:0] bits
);
  logic [WIDTH-1:0] bits_q;
  logic [WIDTH-1:0] hit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    always_comb hit[i] = commit && (cmt_sel == SEL_W'(i));

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)     bits_q[i] <= 1'b0;
      else if (hit[i]) bits_q[i] <= cmt_din;
    end
  end

  assign bits = bits_q;
endmodule

// File: rtl/sld_outmux.sv
module sld_outmux
  import sld_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SEL_W = 3
) (
  input  logic             clr_n,
  input  logic             en_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic [WIDTH-1:0] bits,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] dec;
  sld_mode_e        mode;

  for (genvar i = 0; i < WIDTH; i++) begin : g_dec
    always_comb dec[i] = din && (sel == SEL_W'(i));
  end

  always_comb begin
    mode = mode_of(clr_n, en_n);
    unique case (mode)
      MODE_DEMUX: q = dec;
      MODE_CLEAR: q = '0;
      default:    q = bits;
    endcase
  end
endmodule

// File: rtl/sel_latch_demux.sv
module sel_latch_demux #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr_en_n,
  input  logic             clr_n,
  output logic [WIDTH-1:0] q
);
  logic             arst_n;
  logic             srst_n;
  logic             commit;
  logic [SEL_W-1:0] cmt_sel;
  logic             cmt_din;
  logic [WIDTH-1:0] bits;

  assign arst_n = rst_n & clr_n;

  sld_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (srst_n)
  );

  sld_capture #(.SEL_W(SEL_W)) u_cap (
    .clk     (clk),
    .srst_n  (srst_n),
    .en_n    (wr_en_n),
    .din     (din),
    .sel     (sel),
    .commit  (commit),
    .cmt_sel (cmt_sel),
    .cmt_din (cmt_din)
  );

  sld_store #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_store (
    .clk     (clk),
    .srst_n  (srst_n),
    .commit  (commit),
    .cmt_sel (cmt_sel),
    .cmt_din (cmt_din),
    .bits    (bits)
  );

  sld_outmux #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_out (
    .clr_n (clr_n),
    .en_n  (wr_en_n),
    .din   (din),
    .sel   (sel),
    .bits  (bits),
    .q     (q)
  );
endmodule

// File: rtl/sel_latch_demux_chk.sv
module sel_latch_demux_chk #(
  parameter int WIDTH = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             din,
  input logic [SEL_W-1:0] sel,
  input logic             wr_en_n,
  input logic             clr_n,
  input logic [WIDTH-1:0] q
);
  // R7: clear with enable idle forces all zeros
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && wr_en_n) |-> (q == '0));

  // R6: demultiplex drives at most the selected bit, equal to din
  assert_demux_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !wr_en_n) |-> (($countones(q) == int'(din)) && (q[sel] == din)));

  // R4: idle enable over three edges keeps the output steady
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && $past(clr_n) && wr_en_n && $past(wr_en_n) && $past(wr_en_n, 2))
      |-> $stable(q));

  // R2: with clear idle a single edge alters at most one bit
  assert_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && $past(clr_n) && wr_en_n) |-> ($countones(q ^ $past(q)) <= 1));
endmodule

bind sel_latch_demux sel_latch_demux_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .din     (din),
  .sel     (sel),
  .wr_en_n (wr_en_n),
  .clr_n   (clr_n),
  .q       (q)
);

// File: tb/sel_latch_demux_bench.sv
module sel_latch_demux_bench;
  localparam int W    = 8;
  localparam int SW   = 3;
  localparam int SYNC = 2;

  logic          clk;
  logic          rst_n;
  logic          din;
  logic [SW-1:0] sel;
  logic          wr_en_n;
  logic          clr_n;
  logic [W-1:0]  q;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  bit        m_mem [W];
  bit        m_pend;
  int        m_sel;
  bit        m_din;
  int        m_hold;

  sel_latch_demux #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_sel_latch_demux (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .sel     (sel),
    .wr_en_n (wr_en_n),
    .clr_n   (clr_n),
    .q       (q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] expect_q();
    logic [W-1:0] e;
    e = '0;
    if (clr_n) begin
      for (int i = 0; i < W; i++) e[i] = m_mem[i];
    end else if (!wr_en_n) begin
      e[int'(sel)] = din;
    end
    return e;
  endfunction

  task automatic model_edge();
    if (!rst_n || !clr_n) begin
      m_hold = SYNC;
      m_pend = 0;
      for (int i = 0; i < W; i++) m_mem[i] = 0;
    end else if (m_hold > 0) begin
      m_hold--;
      m_pend = 0;
      for (int i = 0; i < W; i++) m_mem[i] = 0;
    end else if (!wr_en_n) begin
      m_pend = 1;
      m_sel  = int'(sel);
      m_din  = din;
    end else begin
      if (m_pend) m_mem[m_sel] = m_din;
      m_pend = 0;
    end
  endtask

  task automatic check(input string tag);
    logic [W-1:0] e;
    e = expect_q();
    checks++;
    if (q !== e) begin
      errors++;
      $display("FAIL %s: q=%b expected=%b at %0t", tag, q, e, $time);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic write_bit(input int idx, input bit val, input string tag);
    sel = SW'(idx); din = val; wr_en_n = 1'b0;
    step(tag);
    wr_en_n = 1'b1;
    sel = ~sel; din = ~din;
    step(tag);
    step(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; wr_en_n = 1'b1; din = 1'b0; sel = '0;
    m_pend = 0; m_sel = 0; m_din = 0; m_hold = SYNC;
    for (int i = 0; i < W; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step("R1");

    // R2/R3: write each index, odd pattern
    for (int i = 0; i < W; i++) write_bit(i, (i % 3) == 1, "R3");
    for (int i = W - 1; i >= 0; i--) write_bit(i, (i % 2) == 0, "R2");

    // R4: idle enable, wiggle inputs
    for (int i = 0; i < 10; i++) begin
      sel = SW'(i * 5); din = i[0];
      step("R4");
    end

    // R5: change address and data while enable low; last sample wins
    sel = 3'd1; din = 1'b0; wr_en_n = 1'b0; step("R5");
    sel = 3'd4; din = 1'b1;                 step("R5");
    sel = 3'd5; din = 1'b0;                 step("R5");
    wr_en_n = 1'b1; sel = 3'd1; din = 1'b1; step("R5");
    step("R5");

    // R6: demultiplex, checked right after each input change and per clock
    clr_n = 1'b0; wr_en_n = 1'b0;
    for (int i = 0; i < 2 * W; i++) begin
      sel = SW'(i); din = (i / W) == 0;
      #1 check("R6");
      step("R6");
    end

    // R7: clear with enable idle, asynchronous
    wr_en_n = 1'b1;
    #1 check("R7");
    for (int i = 0; i < 6; i++) begin
      sel = SW'(7 - i); din = ~din;
      step("R7");
    end

    // R8: release clear, contents gone, new write later accepted
    clr_n = 1'b1;
    for (int i = 0; i < 4; i++) step("R8");
    write_bit(6, 1'b1, "R8");
    write_bit(0, 1'b1, "R8");
    write_bit(3, 1'b1, "R8");

    // R9: clear in the middle of a write
    sel = 3'd2; din = 1'b1; wr_en_n = 1'b0; step("R9");
    step("R9");
    clr_n = 1'b0;
    #1 check("R9");
    step("R9");
    wr_en_n = 1'b1;
    #1 check("R9");
    step("R9");
    clr_n = 1'b1;
    for (int i = 0; i < 5; i++) step("R9");
    write_bit(5, 1'b1, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule